// File: doc/BRIEF.md
# Stereo ADC Serial-to-Byte Stream Bridge

This block takes the three-wire serial output of a stereo delta-sigma audio converter (bit clock, channel-select clock and serial data) and turns it into a plain byte stream for an 8-bit write-strobed FIFO that leads to a USB host. The converter samples are 24-bit two's complement values. Each one is sent as three bytes, most significant byte first. The left channel of a frame goes out before the right channel, so every stereo frame becomes six bytes.

The stream carries no framing bytes. Alignment comes from waiting for a rising edge of the channel-select clock after reset and after every restart. A restart is requested by a one-cycle indication that the host has sent a byte. It drops everything that is buffered or half-gathered.

The serial clocks are not used as clocks. All three serial lines are brought into the system clock domain, and bit clock rising edges are found there. A small holding buffer rides out short periods when the downstream FIFO is full. If bytes are lost, a sticky flag records it.

Top module: `adc_byte_bridge`

## Requirements
- R1: After reset the write strobe is low and the loss flag is low.
- R2: A data bit is taken at each rising edge of the bit clock. Bits enter most significant first, and each group of 8 bits forms one byte with the first bit received in byte bit 7.
- R3: After reset, no byte is produced until the channel-select clock has been seen going from low to high. Bits of any partial frame before that edge are dropped.
- R4: The slot in which the channel-select line is high is the left channel. Each frame is emitted as left bits 23..16, 15..8, 7..0, then right bits 23..16, 15..8, 7..0.
- R5: Bits past the 24th within one channel slot produce no bytes and do not disturb the next slot.
- R6: A one-cycle host-byte indication empties the holding buffer, clears the loss flag, discards partial bits, and holds output off until the next low-to-high edge of the channel-select clock.
- R7: The write strobe is never high while the FIFO-full input is high. Bytes that arrive during a full period are delivered later, in order, without loss, as long as at most BUF_DEPTH bytes are pending.
- R8: A byte that arrives while the holding buffer already holds BUF_DEPTH bytes and cannot drain is dropped. This sets the loss flag, which stays set until a restart. The bytes already held are still delivered in order.
- R9: While bytes are pending and the FIFO is full, the output data bus holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_clk_i | input | 1 | Converter serial bit clock (asynchronous) |
| chan_clk_i | input | 1 | Converter channel-select clock, high = left (asynchronous) |
| ser_dat_i | input | 1 | Converter serial data, changes on the falling bit clock edge |
| host_byte_i | input | 1 | One-cycle pulse: the host sent a byte, restart |
| fifo_full_i | input | 1 | Downstream FIFO cannot accept a byte |
| fifo_data_o | output | 8 | Byte presented to the FIFO |
| fifo_wr_o | output | 1 | Write strobe; each high cycle transfers one byte |
| lost_o | output | 1 | Sticky flag: at least one byte was dropped |

## Verification
The hardest situation to reach is a buffer overflow that is followed by a restart in the middle of a channel slot. The stimulus holds the FIFO-full input high for a whole left slot, so two bytes are held and a third is dropped. It then pulses the host indication before the right slot arrives and releases backpressure. The bench checks that nothing is written, that the loss flag clears, and that output resumes only at the next left slot. The main sweep covers full-scale, zero and arithmetic sample patterns, with both 24-bit and over-long slots, and starts mid-frame.

// File: rtl/adcb_pkg.sv
package adcb_pkg;
    // lane positions in the synchroniser vector
    localparam int LANE_BCLK = 0;
    localparam int LANE_CCLK = 1;
    localparam int LANE_DATA = 2;
    localparam int LANES     = 3;
endpackage

// File: rtl/adcb_sync.sv
module adcb_sync #(
    parameter int STAGES = 2,
    parameter int W      = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] rise_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
        logic [W-1:0]             last;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        d.chain[0] = raw_i;
        for (int s = 1; s < STAGES; s++) begin
            d.chain[s] = q.chain[s-1];
        end
        d.last = q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sync_o = q.chain[STAGES-1];
    assign rise_o = q.chain[STAGES-1] & ~q.last;
endmodule

// File: rtl/adcb_deser.sv
module adcb_deser #(
    parameter int SAMPLE_BITS = 24,
    parameter int BYTE_BITS   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart_i,
    input  logic                 tick_i,
    input  logic                 lr_i,
    input  logic                 dat_i,
    output logic                 push_o,
    output logic [BYTE_BITS-1:0] byte_o
);
    localparam int IW = $clog2(SAMPLE_BITS + 1);
    localparam logic [IW-1:0] IDLE_IDX = IW'(SAMPLE_BITS);

    typedef struct packed {
        logic                 run;
        logic                 lr_prev;
        logic [IW-1:0]        idx;
        logic [BYTE_BITS-1:0] shreg;
        logic                 push;
        logic [BYTE_BITS-1:0] pbyte;
    } st_t;

    st_t q, d;
    logic          slot_edge, start, live;
    logic [IW-1:0] pos;

    always_comb begin
        d         = q;
        d.push    = 1'b0;
        slot_edge = 1'b0;
        start     = 1'b0;
        live      = 1'b0;
        pos       = q.idx;
        if (restart_i) begin
            d.run = 1'b0;
            d.idx = IDLE_IDX;
        end else if (tick_i) begin
            slot_edge = (lr_i != q.lr_prev);
            start     = slot_edge && lr_i;
            pos       = slot_edge ? '0 : q.idx;
            live      = (q.run || start) && (pos < IDLE_IDX);
            d.lr_prev = lr_i;
            d.idx     = pos;
            if (start) d.run = 1'b1;
            if (live) begin
                d.shreg = {q.shreg[BYTE_BITS-2:0], dat_i};
                d.idx   = pos + 1'b1;
                if ((int'(pos) % BYTE_BITS) == BYTE_BITS - 1) begin
                    d.push  = 1'b1;
                    d.pbyte = {q.shreg[BYTE_BITS-2:0], dat_i};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.lr_prev <= 1'b1;
            q.idx     <= IDLE_IDX;
        end else begin
            q <= d;
        end
    end

    assign push_o = q.push;
    assign byte_o = q.pbyte;

    // R6: a restart never lets a byte out in the following cycle
    p_restart_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !push_o);
    // R2: bytes are only produced on a bit clock rising edge
    p_push_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> $past(tick_i));
endmodule

// File: rtl/adcb_holdbuf.sv
module adcb_holdbuf #(
    parameter int DEPTH = 2,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush_i,
    input  logic         push_i,
    input  logic [W-1:0] byte_i,
    input  logic         full_i,
    output logic         wr_o,
    output logic [W-1:0] data_o,
    output logic         ovf_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CW-1:0]           cnt;
        logic                    ovf;
    } st_t;

    st_t  q, d;
    logic pop, accept;

    always_comb begin
        d      = q;
        pop    = (q.cnt != '0) && !full_i;
        accept = push_i && ((q.cnt != CAP) || pop);
        if (flush_i) begin
            d.rd  = '0;
            d.wr  = '0;
            d.cnt = '0;
            d.ovf = 1'b0;
        end else begin
            if (pop) d.rd = (q.rd == LAST) ? '0 : q.rd + 1'b1;
            if (accept) begin
                d.mem[q.wr] = byte_i;
                d.wr        = (q.wr == LAST) ? '0 : q.wr + 1'b1;
            end
            if (push_i && !accept) d.ovf = 1'b1;
            d.cnt = q.cnt + CW'(accept) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wr_o   = (q.cnt != '0) && !full_i;
    assign data_o = q.mem[q.rd];
    assign ovf_o  = q.ovf;

    // R9: presented byte holds while waiting on a full FIFO
    p_hold_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt != '0 && full_i && !flush_i) |=> (data_o == $past(data_o)));
    // R8: loss flag is sticky until flushed
    p_lost_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !flush_i) |=> ovf_o);
    // R8: occupancy never exceeds the buffer depth
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CAP);
    // R6: a flush leaves nothing to write and no loss flag
    p_flush_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (!wr_o && !ovf_o));
endmodule

// File: rtl/adc_byte_bridge.sv
module adc_byte_bridge #(
    parameter int SYNC_STAGES = 2,
    parameter int SAMPLE_BITS = 24,
    parameter int BUF_DEPTH   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_clk_i,
    input  logic       chan_clk_i,
    input  logic       ser_dat_i,
    input  logic       host_byte_i,
    input  logic       fifo_full_i,
    output logic [7:0] fifo_data_o,
    output logic       fifo_wr_o,
    output logic       lost_o
);
    import adcb_pkg::*;
    localparam int BYTE_BITS = 8;

    logic [LANES-1:0] raw, synced, rises;
    logic             push;
    logic [7:0]       pbyte;

    always_comb begin
        raw            = '0;
        raw[LANE_BCLK] = bit_clk_i;
        raw[LANE_CCLK] = chan_clk_i;
        raw[LANE_DATA] = ser_dat_i;
    end

    adcb_sync #(.STAGES(SYNC_STAGES), .W(LANES)) i_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(raw), .sync_o(synced), .rise_o(rises));

    adcb_deser #(.SAMPLE_BITS(SAMPLE_BITS), .BYTE_BITS(BYTE_BITS)) i_deser (
        .clk(clk), .rst_n(rst_n), .restart_i(host_byte_i),
        .tick_i(rises[LANE_BCLK]), .lr_i(synced[LANE_CCLK]),
        .dat_i(synced[LANE_DATA]), .push_o(push), .byte_o(pbyte));

    adcb_holdbuf #(.DEPTH(BUF_DEPTH), .W(BYTE_BITS)) i_buf (
        .clk(clk), .rst_n(rst_n), .flush_i(host_byte_i), .push_i(push),
        .byte_i(pbyte), .full_i(fifo_full_i), .wr_o(fifo_wr_o),
        .data_o(fifo_data_o), .ovf_o(lost_o));

    // R7: no write strobe toward a full FIFO
    p_no_wr_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full_i |-> !fifo_wr_o);
endmodule

// File: tb/test_adc_byte_bridge.sv
module test_adc_byte_bridge;
    localparam int H = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk = 1'b0, cclk = 1'b0, sdat = 1'b0;
    logic       hostb = 1'b0, full = 1'b0;
    logic [7:0] fdata;
    logic       fwr, lost;

    int checks = 0, bad = 0;
    logic [7:0] got [0:255];
    logic [7:0] expv [0:255];
    int ngot = 0, nexp = 0;

    always #4 clk = ~clk;

    adc_byte_bridge i_adc_byte_bridge (
        .clk(clk), .rst_n(rst_n), .bit_clk_i(bclk), .chan_clk_i(cclk),
        .ser_dat_i(sdat), .host_byte_i(hostb), .fifo_full_i(full),
        .fifo_data_o(fdata), .fifo_wr_o(fwr), .lost_o(lost));

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: take every write, and flag a write into a full FIFO (R7)
    always @(negedge clk) begin
        if (rst_n && fwr) begin
            chk(!full, "R7 write while full", 1, 0);
            if (ngot < 256) got[ngot] = fdata;
            ngot++;
        end
    end

    function automatic logic [23:0] sval(input int i, input int ch);
        logic [23:0] v;
        case (i)
            0: v = ch ? 24'h7FFFFF : 24'h800000;
            1: v = ch ? 24'h000000 : 24'hFFFFFF;
            default: v = 24'(i * 24'h03B5A1 + 24'h800001 + ch * 24'h13579B);
        endcase
        return v;
    endfunction

    task automatic send_slot(input logic lr, input logic [23:0] v, input int total);
        for (int b = 0; b < total; b++) begin
            @(negedge clk);
            bclk = 1'b0;
            cclk = lr;
            sdat = (b < 24) ? v[23 - b] : logic'(b & 1);
            repeat (H) @(negedge clk);
            bclk = 1'b1;
            repeat (H) @(negedge clk);
        end
        bclk = 1'b0;
    endtask

    task automatic exp_slot(input logic [23:0] v);
        expv[nexp] = v[23:16]; expv[nexp+1] = v[15:8]; expv[nexp+2] = v[7:0];
        nexp += 3;
    endtask

    task automatic send_frame(input int i, input int total);
        send_slot(1'b1, sval(i, 0), total);
        send_slot(1'b0, sval(i, 1), total);
    endtask

    task automatic compare(input string tag);
        repeat (30) @(negedge clk);
        chk(ngot == nexp, {tag, " byte count"}, ngot, nexp);
        for (int k = 0; k < nexp && k < ngot; k++)
            chk(got[k] == expv[k], tag, got[k], expv[k]);
        ngot = 0;
        nexp = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(fwr == 1'b0, "R1 strobe after reset", fwr, 0);
        chk(lost == 1'b0, "R1 lost after reset", lost, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R3: start mid-frame (partial right slot), then R2/R4 sweep
        send_slot(1'b0, 24'hABCDEF, 10);
        for (int i = 0; i < 6; i++) begin
            send_frame(i, 24);
            exp_slot(sval(i, 0));
            exp_slot(sval(i, 1));
        end
        compare("R2 R3 R4 frame sweep");

        // R5: over-long 32-bit slots
        for (int i = 6; i < 9; i++) begin
            send_frame(i, 32);
            exp_slot(sval(i, 0));
            exp_slot(sval(i, 1));
        end
        compare("R5 long slots");

        // R7: short full period, no loss
        fork
            begin
                send_frame(9, 24);
                exp_slot(sval(9, 0));
                exp_slot(sval(9, 1));
            end
            begin
                repeat (100) @(negedge clk);
                full = 1'b1;
                repeat (60) @(negedge clk);
                full = 1'b0;
            end
        join
        compare("R7 backpressure");
        chk(lost == 1'b0, "R7 no loss flag", lost, 0);

        // R8: full for a whole frame, two held bytes survive
        full = 1'b1;
        send_frame(10, 24);
        repeat (20) @(negedge clk);
        chk(lost == 1'b1, "R8 loss flag set", lost, 1);
        chk(ngot == 0, "R7 nothing written while full", ngot, 0);
        full = 1'b0;
        expv[0] = sval(10, 0) >> 16; expv[1] = sval(10, 0) >> 8; nexp = 2;
        compare("R8 held bytes");
        chk(lost == 1'b1, "R8 loss flag sticky", lost, 1);

        // R6: restart in mid-frame, with bytes held
        full = 1'b1;
        send_slot(1'b1, sval(11, 0), 24);
        @(negedge clk); hostb = 1'b1;
        @(negedge clk); hostb = 1'b0;
        full = 1'b0;
        repeat (30) @(negedge clk);
        chk(ngot == 0, "R6 buffer emptied", ngot, 0);
        chk(lost == 1'b0, "R6 loss flag cleared", lost, 0);
        send_slot(1'b0, sval(11, 1), 24);
        chk(ngot == 0, "R6 waits for left slot", ngot, 0);
        for (int i = 12; i < 14; i++) begin
            send_frame(i, 24);
            exp_slot(sval(i, 0));
            exp_slot(sval(i, 1));
        end
        compare("R6 after restart");

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule